// File: doc/BRIEF.md
# Clock Output Gating and Power-Down Sequencer

This block sits between a bank of divided clock sources and the output pins of a clock generator. Each lane passes its source clock when its enable bit is set and holds it low when the bit is clear. An enable change is applied only while the lane's source is low, so an output never shows a shortened pulse. One lane is the free-running memory feedback clock and ignores its enable bit. A global tristate bit removes the drive from every pin, and a per-lane output-enable signal tells the pad ring when to drive.

The block also sequences power-down. An asynchronous active-low power-down pin is first synchronized. Lanes marked as fast (the reference and 48 MHz lanes) close as soon as the synchronized request arrives. All other lanes keep running until the next falling edge of the reference standing in for the internal CPU clock, and then close at their next low phase. Once every output has been low for a programmable hold time, the VCO is stopped, and the crystal is stopped one cycle later. On release, the crystal restarts first and the VCO one cycle after it. A settle counter then stands in for the oscillator restart time, and the ready flag rises and the gates reopen only when that counter expires. The same settle period follows reset. Every edge sampled here is taken on the fast sampling clock `clk`. The sources and the CPU reference are level inputs to that clock. The block has no data streams, so all pins are plain control and status signals.

Top module: `clk_gate_pdseq`

## Requirements
- R1: Reset condition and first settle.
  - While reset is held, `clk_out`, `clk_oe`, `ready`, `vco_stop` and `xtal_stop` are all 0.
  - After reset is released, `ready` rises on exactly the SETTLE_CYC-th rising edge of `clk`.
- R2: Running lane.
  - While `ready` is 1 and the lane's enable has been stable for a full source period, `clk_out[i]` equals the `src_clk[i]` value sampled at the previous edge (one cycle of latency).
- R3: Disabled lane.
  - A lane whose `out_en` bit is 0 is held low and does not switch.
- R4: Free-running lane.
  - Lane FREE_IDX (default 2) passes its source whatever the value of `out_en[FREE_IDX]`.
- R5: Glitch-free enable changes.
  - An enable change takes effect only while the lane's source is low.
  - A high phase that has started completes at full length.
  - A newly enabled lane begins with a full high phase.
- R6: Tristate.
  - `clk_oe` is all ones one cycle after `tristate` is 0.
  - `clk_oe` is all zeros one cycle after `tristate` is 1.
- R7: Power-down entry.
  - `pd_n` passes through SYNC_STAGES flops before it acts.
  - Lanes set in FAST_MASK (default bits 6 and 7) close as soon as the synchronized request is low, while the other lanes keep running until a falling edge of `cpu_ref`.
  - `ready` falls when the request is seen.
- R8: VCO stop.
  - `vco_stop` rises only after every output has been low for HOLD_CYC consecutive cycles.
  - Every output stays low while `vco_stop` is 1.
- R9: Stop and restart order.
  - `xtal_stop` rises one cycle after `vco_stop`.
  - On wake, `xtal_stop` falls one cycle before `vco_stop` falls.
  - `xtal_stop` is never 1 while `vco_stop` is 0.
- R10: Wake.
  - After `pd_n` rises with the block stopped, `ready` rises exactly SYNC_STAGES+SETTLE_CYC+2 cycles later.
  - All outputs stay low until then.
  - `ready` is never 1 while either stop control is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all sequencing and gating |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| cpu_ref | input | 1 | Level of the internal CPU clock reference |
| src_clk | input | N_OUT | Ungated divided clock levels, one per lane |
| out_en | input | N_OUT | Per-lane enable bits (1 = run) |
| tristate | input | 1 | Global bit: 1 releases every output pin |
| clk_out | output | N_OUT | Gated clock levels |
| clk_oe | output | N_OUT | Per-lane output drive enable |
| vco_stop | output | 1 | Request to stop the VCO |
| xtal_stop | output | 1 | Request to stop the crystal oscillator |
| ready | output | 1 | Clocks are valid and the gates are open |

## Verification
The lanes run from sources with different half periods of 2, 3, 4, 5 and 8 cycles.
- Full enable against a sparse mask separates real gating from a pass-through, and the sparse mask also shows that the free lane ignores its bit.
- Enable changes are placed mid-high and mid-low on the slowest lane. This separates gating applied in the low phase from a plain AND gate, which would truncate or start a pulse late.
- Power-down is entered with the CPU reference parked high. This shows the fast lanes closing before the others, and the release of the reference then exposes the wait for the falling edge, the low hold, the stop order and the exact wake latency.

// File: rtl/cg_pkg.sv
package cg_pkg;
  typedef enum logic [2:0] {
    ST_WAKE      = 3'd0,
    ST_RUN       = 3'd1,
    ST_STOP_WAIT = 3'd2,
    ST_DRAIN     = 3'd3,
    ST_VCO_OFF   = 3'd4,
    ST_OFF       = 3'd5,
    ST_XTAL_UP   = 3'd6
  } pd_state_t;
endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain[0] <= d;
      for (int k = 1; k < STAGES; k++) begin
        chain[k] <= chain[k-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cg_lane.sv
// One gated lane. The arm flag follows the request only while the source
// is low, so the gated output sees whole high phases or none.
module cg_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic want,
  output logic out,
  output logic lane_off
);
  logic armed_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      if (!src) begin
        armed_q <= want;
      end
      out_q <= src & armed_q;
    end
  end

  assign out      = out_q;
  assign lane_off = ~armed_q & ~out_q;
endmodule

// File: rtl/cg_pd_seq.sv
module cg_pd_seq
  import cg_pkg::*;
#(
  parameter int SETTLE_CYC = 1000,
  parameter int HOLD_CYC   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_s,
  input  logic ref_fall,
  input  logic all_off,
  output logic gate_main,
  output logic gate_fast,
  output logic vco_stop,
  output logic xtal_stop,
  output logic ready
);
  localparam int MAXC  = (SETTLE_CYC > HOLD_CYC) ? SETTLE_CYC : HOLD_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST   = CNT_W'(HOLD_CYC - 1);

  pd_state_t state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = '0;
    unique case (state_q)
      ST_WAKE: begin
        cnt_d = cnt_q + 1'b1;
        if (!pd_s) begin
          state_d = ST_DRAIN;
          cnt_d   = '0;
        end else if (cnt_q == SETTLE_LAST) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end
      end
      ST_RUN: begin
        if (!pd_s) state_d = ST_STOP_WAIT;
      end
      ST_STOP_WAIT: begin
        if (ref_fall) state_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (all_off) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == HOLD_LAST) begin
            state_d = ST_VCO_OFF;
            cnt_d   = '0;
          end
        end
      end
      ST_VCO_OFF: state_d = ST_OFF;
      ST_OFF: begin
        if (pd_s) state_d = ST_XTAL_UP;
      end
      ST_XTAL_UP: state_d = ST_WAKE;
      default: state_d = ST_WAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAKE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign gate_main = (state_q == ST_RUN) || (state_q == ST_STOP_WAIT);
  assign gate_fast = (state_q == ST_RUN);
  assign vco_stop  = (state_q == ST_VCO_OFF) || (state_q == ST_OFF) ||
                     (state_q == ST_XTAL_UP);
  assign xtal_stop = (state_q == ST_OFF);
  assign ready     = (state_q == ST_RUN);
endmodule

// File: rtl/clk_gate_pdseq.sv
module clk_gate_pdseq #(
  parameter int               N_OUT       = 8,
  parameter int               FREE_IDX    = 2,
  parameter logic [N_OUT-1:0] FAST_MASK   = 8'b1100_0000,
  parameter int               SYNC_STAGES = 2,
  parameter int               SETTLE_CYC  = 1000,
  parameter int               HOLD_CYC    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_n,
  input  logic             cpu_ref,
  input  logic [N_OUT-1:0] src_clk,
  input  logic [N_OUT-1:0] out_en,
  input  logic             tristate,
  output logic [N_OUT-1:0] clk_out,
  output logic [N_OUT-1:0] clk_oe,
  output logic             vco_stop,
  output logic             xtal_stop,
  output logic             ready
);
  logic             pd_s;
  logic             ref_q;
  logic             ref_fall;
  logic             gate_main, gate_fast;
  logic [N_OUT-1:0] lane_off;
  logic [N_OUT-1:0] want;

  cg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pd_sync (
    .clk(clk), .rst_n(rst_n), .d(pd_n), .q(pd_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= 1'b0;
    else        ref_q <= cpu_ref;
  end
  assign ref_fall = ref_q & ~cpu_ref;

  cg_pd_seq #(.SETTLE_CYC(SETTLE_CYC), .HOLD_CYC(HOLD_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .pd_s(pd_s), .ref_fall(ref_fall),
    .all_off(&lane_off), .gate_main(gate_main), .gate_fast(gate_fast),
    .vco_stop(vco_stop), .xtal_stop(xtal_stop), .ready(ready)
  );

  for (genvar g = 0; g < N_OUT; g++) begin : g_lane
    logic gate_g;
    if (FAST_MASK[g]) begin : g_fast
      assign gate_g = gate_fast;
    end else begin : g_main
      assign gate_g = gate_main;
    end
    if (g == FREE_IDX) begin : g_free
      assign want[g] = gate_g;
    end else begin : g_ctl
      assign want[g] = gate_g & out_en[g];
    end
    cg_lane u_lane (
      .clk(clk), .rst_n(rst_n), .src(src_clk[g]), .want(want[g]),
      .out(clk_out[g]), .lane_off(lane_off[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_oe <= '0;
    else        clk_oe <= {N_OUT{~tristate}};
  end
endmodule

// File: rtl/cg_checker.sv
module cg_checker #(
  parameter int N_OUT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_OUT-1:0] src_clk,
  input logic [N_OUT-1:0] clk_out,
  input logic [N_OUT-1:0] clk_oe,
  input logic             tristate,
  input logic             vco_stop,
  input logic             xtal_stop,
  input logic             ready
);
  for (genvar g = 0; g < N_OUT; g++) begin : g_chk
    a_r5_no_runt: assert property (@(posedge clk) disable iff (!rst_n)
      (src_clk[g] && $past(src_clk[g])) |=> $stable(clk_out[g]));
  end

  a_r6_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    tristate |=> (clk_oe == '0));
  a_r6_oe_on: assert property (@(posedge clk) disable iff (!rst_n)
    !tristate |=> (clk_oe == '1));
  a_r8_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    vco_stop |-> (clk_out == '0));
  a_r9_xtal_inside_vco: assert property (@(posedge clk) disable iff (!rst_n)
    xtal_stop |-> vco_stop);
  a_r9_xtal_after_vco: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xtal_stop) |-> $past(vco_stop));
  a_r10_ready_clean: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!vco_stop && !xtal_stop));
endmodule

bind clk_gate_pdseq cg_checker #(.N_OUT(N_OUT)) i_cg_checker (
  .clk(clk), .rst_n(rst_n), .src_clk(src_clk), .clk_out(clk_out),
  .clk_oe(clk_oe), .tristate(tristate), .vco_stop(vco_stop),
  .xtal_stop(xtal_stop), .ready(ready)
);

// File: tb/test_clk_gate_pdseq.sv
`timescale 1ns/1ps
module test_clk_gate_pdseq;
  localparam int N = 8;
  localparam int S = 24;
  localparam int H = 4;
  localparam int HP[8] = '{2, 2, 2, 4, 3, 8, 5, 3};

  logic clk = 1'b0;
  logic rst_n, pd_n, cpu_ref, tristate;
  logic [N-1:0] src_clk, out_en, clk_out, clk_oe;
  logic vco_stop, xtal_stop, ready;

  always #2.5 clk = ~clk;

  clk_gate_pdseq #(.N_OUT(N), .FREE_IDX(2), .FAST_MASK(8'b1100_0000),
                   .SYNC_STAGES(2), .SETTLE_CYC(S), .HOLD_CYC(H)) i_clk_gate_pdseq (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .cpu_ref(cpu_ref),
    .src_clk(src_clk), .out_en(out_en), .tristate(tristate),
    .clk_out(clk_out), .clk_oe(clk_oe), .vco_stop(vco_stop),
    .xtal_stop(xtal_stop), .ready(ready)
  );

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  bit done = 0;
  bit sb_on = 0;
  bit force_ref = 0;
  logic [N-1:0] seen_hi = '0;

  typedef struct { int due; logic [N-1:0] exp; } sb_item_t;
  sb_item_t sbq[$];

  function automatic logic [N-1:0] pat(int c);
    logic [N-1:0] p;
    for (int i = 0; i < N; i++) p[i] = ((c / HP[i]) % 2) == 1;
    return p;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s cyc=%0d actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  task automatic wait_cyc(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    seen_hi <= seen_hi | clk_out;
  end

  // driver: sources, CPU reference and expected items
  always @(posedge clk) begin
    #1;
    src_clk = pat(cyc);
    cpu_ref = force_ref ? 1'b1 : pat(cyc)[0];
    if (sb_on) sbq.push_back('{due: cyc + 1, exp: pat(cyc) & (out_en | 8'h04)});
  end

  // monitor: compare the outputs against due items
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due < cyc) void'(sbq.pop_front());
    if (sbq.size() > 0 && sbq[0].due == cyc) begin
      sb_item_t it;
      it = sbq.pop_front();
      chk(clk_out == it.exp, "R2 R3 R4 lane pattern", 32'(clk_out), 32'(it.exp));
    end
  end

  task automatic run_sb(input int n);
    repeat (20) @(negedge clk);
    sb_on = 1;
    repeat (n) @(negedge clk);
    sb_on = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int base;
    int lowrun;
    bit got;
    rst_n = 0; pd_n = 1; tristate = 0; out_en = 8'hFF;
    src_clk = '0; cpu_ref = 0;
    repeat (4) @(negedge clk);
    // R1 reset condition
    chk({clk_out, clk_oe, ready, vco_stop, xtal_stop} == '0, "R1 reset outputs",
        32'({clk_out, clk_oe, ready, vco_stop, xtal_stop}), 0);
    rst_n = 1;
    base = cyc;
    wait_cyc(base + S - 1);
    chk(ready == 1'b0, "R1 ready early", 32'(ready), 0);
    @(negedge clk);
    chk(ready == 1'b1, "R1 ready after settle", 32'(ready), 1);

    // R2 all enabled
    run_sb(80);
    // R3, R4 sparse mask with the free lane bit cleared
    out_en = 8'h52;
    repeat (20) @(negedge clk);
    seen_hi = '0;
    run_sb(80);
    chk(seen_hi[2] == 1'b1, "R4 free lane runs", 32'(seen_hi[2]), 1);
    chk((seen_hi & 8'hA9) == '0, "R3 disabled lanes low", 32'(seen_hi & 8'hA9), 0);

    // R5 disable lane 5 in mid-high
    out_en = 8'hFF;
    repeat (20) @(negedge clk);
    while (cyc % 16 != 10) @(negedge clk);
    base = cyc;
    out_en[5] = 1'b0;
    wait_cyc(base + 6);
    chk(clk_out[5] == 1'b1, "R5 high phase completes", 32'(clk_out[5]), 1);
    wait_cyc(base + 7);
    seen_hi = '0;
    wait_cyc(base + 30);
    chk(seen_hi[5] == 1'b0 && clk_out[5] == 1'b0, "R3 R5 lane stays low",
        32'(seen_hi[5]), 0);
    // R5 enable lane 5 in mid-low
    while (cyc % 16 != 2) @(negedge clk);
    base = cyc;
    out_en[5] = 1'b1;
    wait_cyc(base + 6);
    chk(clk_out[5] == 1'b0, "R5 no early start", 32'(clk_out[5]), 0);
    @(negedge clk);
    chk(clk_out[5] == 1'b1, "R5 full high starts", 32'(clk_out[5]), 1);

    // R6 tristate
    tristate = 1;
    @(negedge clk);
    chk(clk_oe == '0, "R6 oe released", 32'(clk_oe), 0);
    tristate = 0;
    @(negedge clk);
    chk(clk_oe == '1, "R6 oe driven", 32'(clk_oe), 32'hFF);

    // R7 power-down entry with the CPU reference parked high
    repeat (20) @(negedge clk);
    force_ref = 1;
    repeat (3) @(negedge clk);
    pd_n = 0;
    repeat (20) @(negedge clk);
    seen_hi = '0;
    repeat (30) @(negedge clk);
    chk(seen_hi[7:6] == 2'b00, "R7 fast lanes stopped", 32'(seen_hi[7:6]), 0);
    chk(seen_hi[3] == 1'b1, "R7 other lanes wait for cpu fall", 32'(seen_hi[3]), 1);
    chk(ready == 1'b0, "R7 ready dropped", 32'(ready), 0);
    chk(vco_stop == 1'b0, "R8 vco runs while lanes active", 32'(vco_stop), 0);

    // R8 VCO stop after the low hold
    force_ref = 0;
    lowrun = 0; got = 0;
    for (int i = 0; i < 200 && !got; i++) begin
      @(negedge clk);
      if (vco_stop) got = 1;
      else lowrun = (clk_out == '0) ? lowrun + 1 : 0;
    end
    chk(got, "R8 vco stops", 32'(got), 1);
    chk(lowrun >= H, "R8 low hold before vco stop", 32'(lowrun), 32'(H));
    chk(xtal_stop == 1'b0, "R9 crystal still on", 32'(xtal_stop), 0);
    @(negedge clk);
    chk(xtal_stop == 1'b1, "R9 crystal stops next cycle", 32'(xtal_stop), 1);
    seen_hi = '0;
    repeat (10) @(negedge clk);
    chk(seen_hi == '0, "R8 outputs low while stopped", 32'(seen_hi), 0);

    // R10 wake
    pd_n = 1;
    base = cyc;
    wait_cyc(base + 3);
    chk(xtal_stop == 1'b0 && vco_stop == 1'b1, "R9 crystal restarts first",
        32'({xtal_stop, vco_stop}), 32'b01);
    @(negedge clk);
    chk(vco_stop == 1'b0, "R9 vco restarts", 32'(vco_stop), 0);
    wait_cyc(base + 3 + S);
    chk(ready == 1'b0 && seen_hi == '0, "R10 quiet until settled",
        32'({ready, seen_hi}), 0);
    @(negedge clk);
    chk(ready == 1'b1, "R10 wake latency", 32'(ready), 1);
    run_sb(60);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule